// File: doc/BRIEF.md
# Multi-Bank DRAM Command Sequencer

This block sits between a cache and one rank of DRAM. It accepts one cache-block request at a time, either a read or a write, addressed by bank, row and starting column, and converts it into the short list of commands the DRAM needs. For each of its eight banks the sequencer keeps the row currently held in that bank's row buffer, or a mark saying the bank has no open row. A request is sorted into one of three cases: it hits the open row, it finds the bank empty, or it conflicts with a different open row. Only the commands needed for that case are issued.

All banks share one command bus, so at most one command goes out per cycle. A 64-byte block is moved as eight 64-bit beats, one per column, on eight back-to-back column commands within a single row. A free-running interval counter requests a refresh. Once the block in flight has finished, the refresh request takes precedence over new requests: every open bank is closed and then a refresh command is issued. The minimum spacing between commands is set by cycle-count parameters.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset every bank is marked closed, `reqReady` is high, `cmdOp` is NOP (0) and `accStatusValid` is low.
- R2: A request to a bank with no open row issues ACT (1) with the request's bank and row in the cycle after acceptance, and then the column commands; its status is 2'b01.
- R3: A request whose row equals the bank's open row issues its first column command in the cycle after acceptance, with no ACT or PRE; its status is 2'b00.
- R4: A request to a bank holding a different row issues PRE (4) to that bank in the cycle after acceptance, then ACT for the new row, then the column commands; its status is 2'b10.
- R5: A bank closed by a precharge is marked as having no open row, so the next request to it is classified empty.
- R6: Each block is eight column commands on consecutive cycles, RD (2) for a read and WR (3) for a write. All eight use the request's bank and row, and their columns run from base to base+7, where base is the request column with its low three bits cleared. Write beat i carries bits [64*i+63 : 64*i] of `reqWdata`.
- R7: Banks keep their open rows independently: opening a row in one bank leaves another bank's open row, and its hits, unchanged.
- R8: `accStatusValid` is high only in the cycle of an access's first column command, and `accStatus` then holds the access's code (never 2'b11).
- R9: Each command is held until its gap has expired. An ACT comes exactly T_RCD cycles before the first column command that follows it, or T_RP cycles after a PRE that precedes it. No command follows a REF (5) by fewer than T_RFC cycles.
- R10: The refresh counter starts from zero at reset. The first REF comes no earlier than REF_INTERVAL cycles after reset, and successive REFs are at most REF_INTERVAL plus the length of one transfer and the refresh precharges apart. Every open bank is precharged before a REF, and the REF follows the last precharge by at least T_RP cycles.
- R11: A refresh never interrupts a block in flight. `reqReady` is low from acceptance until the block's last column command, and it stays low while a refresh is pending or in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer can accept a request this cycle |
| reqWrite | input | 1 | 1 = write block, 0 = read block |
| reqBank | input | 3 | Target bank |
| reqRow | input | 14 | Target row |
| reqCol | input | 10 | Starting column; the low three bits are ignored |
| reqWdata | input | 512 | Write block, beat i in bits [64*i+63 : 64*i] |
| cmdOp | output | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 REF |
| cmdBank | output | 3 | Bank field of the command |
| cmdRow | output | 14 | Row field of the command |
| cmdCol | output | 10 | Column field of the command |
| cmdWdata | output | 64 | Data beat sent with a WR |
| accStatus | output | 2 | Access kind: 00 hit, 01 empty, 10 conflict |
| accStatusValid | output | 1 | Marks the first column command of an access |

## Verification
Timing is counted from the clock edge that accepts a request. A hit puts its first column command on the bus in the next cycle. An empty access puts ACT there and its first column command T_RCD cycles later. A conflict puts PRE there, ACT T_RP cycles later, and its first column command a further T_RCD cycles on; the eight beats then follow on consecutive cycles. For every cycle from acceptance to the last beat, the bench predicts the exact command, its fields and the status strobe, and compares them at the falling edge. A separate monitor watches refresh, which has no fixed latency: it checks that no bank opened on the bus is still open at each REF, and it checks the spacing between successive REFs against a bound.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmdOp_e;

  typedef enum logic [1:0] {
    ACC_HIT      = 2'd0,
    ACC_EMPTY    = 2'd1,
    ACC_CONFLICT = 2'd2
  } accKind_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic accept;    // latch the offered request
    logic closeReq;  // precharge the bank of the current request
    logic closeRef;  // precharge the lowest open bank for refresh
    logic openReq;   // activate the current request's row
    logic colStep;   // one column beat issued
  } seqStrobe_t;

endpackage

// File: rtl/dcs_datapath.sv
module dcs_datapath
  import dcs_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int BEATS     = 8,
  parameter int DATA_W    = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int BEAT_W   = $clog2(BEATS),
  localparam int BLOCK_W  = DATA_W * BEATS
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic               reqWrite,
  input  logic [BANK_W-1:0]  reqBank,
  input  logic [ROW_W-1:0]   reqRow,
  input  logic [COL_W-1:0]   reqCol,
  input  logic [BLOCK_W-1:0] reqWdata,
  output accKind_e           reqKind,
  output accKind_e           curKind,
  output logic               anyOpen,
  output logic               isWrite,
  output logic               beatFirst,
  output logic               beatLast,
  output logic [BANK_W-1:0]  cmdBank,
  output logic [ROW_W-1:0]   cmdRow,
  output logic [COL_W-1:0]   cmdCol,
  output logic [DATA_W-1:0]  cmdWdata
);

  logic [NUM_BANKS-1:0] openValid;
  logic [ROW_W-1:0]     openRow [NUM_BANKS];
  logic [BANK_W-1:0]    refBank;
  logic [BANK_W-1:0]    curBank;
  logic [ROW_W-1:0]     curRow;
  logic [COL_W-1:0]     curColBase;
  logic [BLOCK_W-1:0]   curData;
  logic [BEAT_W-1:0]    beat;

  // Per-bank open-row table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      openValid <= '0;
      for (int i = 0; i < NUM_BANKS; i++) openRow[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        if (strobe.openReq && curBank == BANK_W'(i)) begin
          openValid[i] <= 1'b1;
          openRow[i]   <= curRow;
        end else if ((strobe.closeReq && curBank == BANK_W'(i)) ||
                     (strobe.closeRef && refBank == BANK_W'(i))) begin
          openValid[i] <= 1'b0;
        end
      end
    end
  end

  // Lowest-numbered open bank is closed first during refresh
  always_comb begin
    refBank = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--)
      if (openValid[i]) refBank = BANK_W'(i);
  end

  assign anyOpen = |openValid;

  always_comb begin
    if (!openValid[reqBank])            reqKind = ACC_EMPTY;
    else if (openRow[reqBank] == reqRow) reqKind = ACC_HIT;
    else                                 reqKind = ACC_CONFLICT;
  end

  // Request latch and beat counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      isWrite    <= 1'b0;
      curBank    <= '0;
      curRow     <= '0;
      curColBase <= '0;
      curData    <= '0;
      curKind    <= ACC_HIT;
      beat       <= '0;
    end else if (strobe.accept) begin
      isWrite    <= reqWrite;
      curBank    <= reqBank;
      curRow     <= reqRow;
      curColBase <= {reqCol[COL_W-1:BEAT_W], BEAT_W'(0)};
      curData    <= reqWdata;
      curKind    <= reqKind;
      beat       <= '0;
    end else if (strobe.colStep) begin
      beat <= beat + 1'b1;
    end
  end

  assign beatFirst = (beat == '0);
  assign beatLast  = (beat == BEAT_W'(BEATS - 1));
  assign cmdBank   = strobe.closeRef ? refBank : curBank;
  assign cmdRow    = curRow;
  assign cmdCol    = curColBase | COL_W'(beat);
  assign cmdWdata  = curData[beat*DATA_W +: DATA_W];

endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
#(
  parameter int T_RCD        = 3,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 6,
  parameter int REF_INTERVAL = 300,
  localparam int GAP_MAX     = (T_RFC > T_RCD) ? ((T_RFC > T_RP) ? T_RFC : T_RP)
                                               : ((T_RCD > T_RP) ? T_RCD : T_RP),
  localparam int GAP_W       = $clog2(GAP_MAX + 1),
  localparam int REF_W       = $clog2(REF_INTERVAL + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  accKind_e   reqKind,
  input  logic       anyOpen,
  input  logic       isWrite,
  input  logic       beatFirst,
  input  logic       beatLast,
  output logic       reqReady,
  output seqStrobe_t strobe,
  output cmdOp_e     cmdOp,
  output logic       statusValid
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_COL, ST_RPRE, ST_RWAIT
  } seqState_e;

  seqState_e        state, nextState;
  logic [GAP_W-1:0] gapCnt, gapVal;
  logic             gapLoad, gapZero;
  logic [REF_W-1:0] refCnt;
  logic             refPending, refTick, refClear;

  assign gapZero = (gapCnt == '0);
  assign refTick = (refCnt == REF_W'(REF_INTERVAL - 1));

  always_comb begin
    nextState   = state;
    strobe      = '0;
    cmdOp       = CMD_NOP;
    reqReady    = 1'b0;
    statusValid = 1'b0;
    gapLoad     = 1'b0;
    gapVal      = '0;
    refClear    = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = !refPending;
        if (refPending) nextState = ST_RPRE;
        else if (reqValid) begin
          strobe.accept = 1'b1;
          case (reqKind)
            ACC_HIT:   nextState = ST_COL;
            ACC_EMPTY: nextState = ST_ACT;
            default:   nextState = ST_PRE;
          endcase
        end
      end
      ST_PRE: if (gapZero) begin
        cmdOp = CMD_PRE;  strobe.closeReq = 1'b1;
        gapLoad = 1'b1;   gapVal = GAP_W'(T_RP - 1);
        nextState = ST_ACT;
      end
      ST_ACT: if (gapZero) begin
        cmdOp = CMD_ACT;  strobe.openReq = 1'b1;
        gapLoad = 1'b1;   gapVal = GAP_W'(T_RCD - 1);
        nextState = ST_COL;
      end
      ST_COL: if (gapZero) begin
        cmdOp = isWrite ? CMD_WR : CMD_RD;
        strobe.colStep = 1'b1;
        statusValid = beatFirst;
        if (beatLast) nextState = ST_IDLE;
      end
      ST_RPRE: begin
        if (anyOpen) begin
          cmdOp = CMD_PRE;  strobe.closeRef = 1'b1;
          gapLoad = 1'b1;   gapVal = GAP_W'(T_RP - 1);
        end else if (gapZero) begin
          cmdOp = CMD_REF;  refClear = 1'b1;
          gapLoad = 1'b1;   gapVal = GAP_W'(T_RFC - 1);
          nextState = ST_RWAIT;
        end
      end
      ST_RWAIT: if (gapZero) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      gapCnt     <= '0;
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      state <= nextState;
      if (gapLoad)       gapCnt <= gapVal;
      else if (!gapZero) gapCnt <= gapCnt - 1'b1;
      refCnt     <= refTick ? '0 : refCnt + 1'b1;
      refPending <= (refPending && !refClear) || refTick;
    end
  end

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dcs_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int ROW_W        = 14,
  parameter int COL_W        = 10,
  parameter int BEATS        = 8,
  parameter int DATA_W       = 64,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 6,
  parameter int REF_INTERVAL = 300,
  localparam int BANK_W      = $clog2(NUM_BANKS),
  localparam int BLOCK_W     = DATA_W * BEATS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [BANK_W-1:0]  reqBank,
  input  logic [ROW_W-1:0]   reqRow,
  input  logic [COL_W-1:0]   reqCol,
  input  logic [BLOCK_W-1:0] reqWdata,
  output logic [2:0]         cmdOp,
  output logic [BANK_W-1:0]  cmdBank,
  output logic [ROW_W-1:0]   cmdRow,
  output logic [COL_W-1:0]   cmdCol,
  output logic [DATA_W-1:0]  cmdWdata,
  output logic [1:0]         accStatus,
  output logic               accStatusValid
);

  seqStrobe_t strobe;
  accKind_e   reqKind, curKind;
  cmdOp_e     opEnum;
  logic       anyOpen, isWrite, beatFirst, beatLast;

  dcs_ctrl #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .REF_INTERVAL(REF_INTERVAL)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .anyOpen(anyOpen), .isWrite(isWrite), .beatFirst(beatFirst),
    .beatLast(beatLast), .reqReady(reqReady), .strobe(strobe),
    .cmdOp(opEnum), .statusValid(accStatusValid)
  );

  dcs_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
    .BEATS(BEATS), .DATA_W(DATA_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata),
    .reqKind(reqKind), .curKind(curKind), .anyOpen(anyOpen),
    .isWrite(isWrite), .beatFirst(beatFirst), .beatLast(beatLast),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol), .cmdWdata(cmdWdata)
  );

  assign cmdOp     = opEnum;
  assign accStatus = curKind;

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 2,
  parameter int T_RFC = 6,
  localparam int CW   = $clog2(T_RCD + T_RP + T_RFC + 2) + 1
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] cmdOp,
  input logic       reqValid,
  input logic       reqReady,
  input logic [1:0] accStatus,
  input logic       accStatusValid
);

  logic [CW-1:0] sinceAct, sincePre, sinceRef;
  logic          isCol;

  assign isCol = (cmdOp == 3'd2) || (cmdOp == 3'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= '1;
      sincePre <= '1;
      sinceRef <= '1;
    end else begin
      sinceAct <= (cmdOp == 3'd1) ? CW'(1) : ((sinceAct == '1) ? sinceAct : sinceAct + 1'b1);
      sincePre <= (cmdOp == 3'd4) ? CW'(1) : ((sincePre == '1) ? sincePre : sincePre + 1'b1);
      sinceRef <= (cmdOp == 3'd5) ? CW'(1) : ((sinceRef == '1) ? sinceRef : sinceRef + 1'b1);
    end
  end

  assert_act_to_col_R9: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> sinceAct >= CW'(T_RCD));
  assert_pre_to_act_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1) |-> sincePre >= CW'(T_RP));
  assert_after_ref_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp != 3'd0) |-> sinceRef >= CW'(T_RFC));
  assert_pre_to_ref_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd5) |-> sincePre >= CW'(T_RP));
  assert_status_on_col_R8: assert property (@(posedge clk) disable iff (!rstN)
    accStatusValid |-> isCol);
  assert_status_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    accStatusValid |-> accStatus != 2'b11);
  assert_hit_no_act_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accStatusValid && accStatus == 2'b00) |-> $past(cmdOp) != 3'd1);
  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  assert_ref_not_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd5) |-> !reqReady);
  assert_legal_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp <= 3'd5);

endmodule

bind dram_cmd_seq dcs_checker #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)) i_checker (
  .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .reqValid(reqValid), .reqReady(reqReady),
  .accStatus(accStatus), .accStatusValid(accStatusValid)
);

// File: tb/test_dram_cmd_seq.sv
`timescale 1ns/1ps
module test_dram_cmd_seq;

  localparam int T_RCD = 3, T_RP = 2, T_RFC = 6, REF_INTERVAL = 300;
  localparam int REF_SLACK = 40;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqWrite = 1'b0;
  logic [2:0]   reqBank = '0;
  logic [13:0]  reqRow = '0;
  logic [9:0]   reqCol = '0;
  logic [511:0] reqWdata = '0;
  logic         reqReady, accStatusValid;
  logic [2:0]   cmdOp, cmdBank;
  logic [13:0]  cmdRow;
  logic [9:0]   cmdCol;
  logic [63:0]  cmdWdata;
  logic [1:0]   accStatus;

  dram_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .REF_INTERVAL(REF_INTERVAL))
  i_dram_cmd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWdata(reqWdata), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .cmdCol(cmdCol), .cmdWdata(cmdWdata), .accStatus(accStatus),
    .accStatusValid(accStatusValid)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // bench model of open rows (from requirements)
  bit        modelValid [8];
  bit [13:0] modelRow [8];
  bit        closedByRef [8];
  bit [7:0]  busOpen = '0;
  bit        inXfer = 0;
  int        cyc = 0, lastRef = -1, refCount = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor: refresh rules
  always @(negedge clk) begin
    if (rstN && !done) begin
      cyc++;
      if (cmdOp == 3'd1) busOpen[cmdBank] = 1'b1;
      if (cmdOp == 3'd4) busOpen[cmdBank] = 1'b0;
      if (cmdOp == 3'd5) begin
        check(busOpen == 8'h00, "R10 banks closed at REF", busOpen, 0);
        check(!reqReady, "R11 ready low at REF", reqReady, 0);
        check(!inXfer, "R11 REF outside transfer", inXfer, 0);
        if (lastRef < 0)
          check(cyc >= REF_INTERVAL, "R10 first REF time", cyc, REF_INTERVAL);
        else
          check(cyc - lastRef <= REF_INTERVAL + REF_SLACK, "R10 REF spacing",
                cyc - lastRef, REF_INTERVAL + REF_SLACK);
        lastRef = cyc;
        refCount++;
        for (int b = 0; b < 8; b++) begin
          if (modelValid[b]) closedByRef[b] = 1;
          modelValid[b] = 0;
        end
      end
    end
  end

  task automatic doReq(input bit w, input bit [2:0] b, input bit [13:0] r,
                       input bit [9:0] c, input bit [511:0] d, input string tag);
    int kind, preK, actK, c0, lastK;
    bit ok;
    string why;
    longint av, ev;
    bit [9:0] base;
    bit wasRefClosed;
    @(negedge clk);
    reqWrite = w; reqBank = b; reqRow = r; reqCol = c; reqWdata = d; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    kind = !modelValid[b] ? 1 : (modelRow[b] == r ? 0 : 2);
    wasRefClosed = closedByRef[b];
    preK = (kind == 2) ? 1 : -1;
    actK = (kind == 2) ? 1 + T_RP : (kind == 1 ? 1 : -1);
    c0   = (kind == 0) ? 1 : actK + T_RCD;
    lastK = c0 + 7;
    base = {c[9:3], 3'b000};
    ok = 1; why = ""; av = 0; ev = 0;
    @(posedge clk);
    inXfer = 1;
    for (int k = 1; k <= lastK; k++) begin
      int expOp;
      bit expSv, thisOk;
      @(negedge clk);
      if (k == 1) reqValid = 1'b0;
      if (k == preK) expOp = 4;
      else if (k == actK) expOp = 1;
      else if (k >= c0) expOp = w ? 3 : 2;
      else expOp = 0;
      expSv = (k == c0);
      thisOk = (cmdOp == 3'(expOp)) && (accStatusValid == expSv);
      if (expOp != 0) thisOk &= (cmdBank == b);
      if (expOp == 1 || expOp >= 2 && expOp <= 3) thisOk &= (cmdRow == r);
      if (expOp == 2 || expOp == 3) thisOk &= (cmdCol == base + 10'(k - c0));
      if (expOp == 3) thisOk &= (cmdWdata == d[64*(k-c0) +: 64]);
      if (!thisOk && ok) begin
        ok = 0;
        av = {cmdOp, cmdBank, cmdCol}; ev = {3'(expOp), b, base + 10'(k - c0)};
        $display("  mismatch at cycle +%0d", k);
      end
      if (expSv)
        check(accStatus == 2'(kind),
              (kind == 1 && wasRefClosed) ? {tag, " R5 R8 status"} : {tag, " R8 status"},
              accStatus, kind);
    end
    case (kind)
      0: why = {tag, " R3/R6/R9 hit sequence"};
      1: why = {tag, " R2/R6/R9 empty sequence"};
      default: why = {tag, " R4/R6/R9 conflict sequence"};
    endcase
    check(ok, why, av, ev);
    inXfer = 0;
    modelValid[b] = 1; modelRow[b] = r; closedByRef[b] = 0;
  endtask

  function automatic bit [511:0] randBlock();
    bit [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_1234);
    for (int b = 0; b < 8; b++) begin modelValid[b] = 0; modelRow[b] = 0; closedByRef[b] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    check(cmdOp == 3'd0, "R1 NOP after reset", cmdOp, 0);
    check(accStatusValid == 1'b0, "R1 no status after reset", accStatusValid, 0);

    doReq(0, 3'd0, 14'd5, 10'h013, randBlock(), "R1 first access empty");
    doReq(1, 3'd0, 14'd5, 10'h03F, randBlock(), "hit write");
    doReq(0, 3'd3, 14'd7, 10'h000, randBlock(), "other bank");
    doReq(0, 3'd0, 14'd5, 10'h105, randBlock(), "R7 bank0 kept");
    doReq(1, 3'd0, 14'd9, 10'h3FF, randBlock(), "conflict");
    doReq(1, 3'd3, 14'd7, 10'h2A8, randBlock(), "R7 bank3 kept");

    for (int n = 0; n < 220; n++) begin
      int gap;
      doReq(1'($urandom), 3'($urandom), 14'($urandom % 3), 10'($urandom),
            randBlock(), "random");
      gap = $urandom % 4;
      repeat (gap) @(negedge clk);
    end
    check(refCount >= 3, "R10 refresh count", refCount, 3);
    done = 1;
    summary();
  end

endmodule